// File: doc/BRIEF.md
# Order-Preserving Round-Robin Block Distributor

This block sequences whole-block transfers between one input node, a set of processing nodes and one output node. It holds two channels. The distribution channel hands each block waiting upstream to the processing nodes in a fixed rotation: node 0, node 1, up to node NODES-1, then node 0 again. The collection channel pulls result blocks back from the processing nodes in the same rotation and hands them on to the output node. Because both channels walk the same sequence, blocks leave in the order they arrived, and no tag is needed.

The block moves no payload. It only decides when a transfer may begin and which node takes part. A transfer begins only when both ends are ready. It ends when the node that took part returns a done strobe. Each channel has at most one transfer in flight. The two channels run independently of each other, because each processing node keeps its incoming and outgoing buffers apart.

Top module: `rr_block_mover`

## Requirements
- R1: After synchronous reset, both node pointers read 0, and all start strobes, the release strobe and the deliver strobe are low.
- R2: A start strobe is a one-cycle, one-hot pulse whose bit k selects node k. It appears one clock after the block saw both ends ready. For distribution, both ends ready means src_blk_ready is high and node_in_free[ptr] is high. For collection, it means node_res_ready[ptr] is high and sink_free is high.
- R3: Distribution targets nodes in the order 0, 1, ..., NODES-1, then wraps to 0.
- R4: Collection takes results from nodes in the same order as distribution, starting at node 0.
- R5: A pointer (dist_node, coll_node) stays on its node while that node is not ready. It never skips to another node, even when other nodes are ready.
- R6: While a transfer is in flight, the channel issues no new start. A done strobe from any node other than the current one has no effect.
- R7: A done strobe from the current node during a transfer advances the pointer at the next clock. On that same clock the channel raises src_blk_release (distribution) or sink_blk_valid (collection) for one cycle. No start is issued in that cycle.
- R8: Every block that enters is delivered exactly once, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_blk_ready | input | 1 | Upstream buffer holds a complete block |
| src_blk_release | output | 1 | One-cycle pulse: the upstream block has been handed over |
| node_in_free | input | NODES | Per-node flag: the node's input buffer is free |
| dist_start | output | NODES | One-hot start strobe for a distribution transfer |
| dist_done | input | NODES | Per-node done strobe for a distribution transfer |
| dist_node | output | PTR_W | Current distribution target |
| node_res_ready | input | NODES | Per-node flag: the node's output buffer holds a result |
| sink_free | input | 1 | The output node has a free buffer |
| coll_start | output | NODES | One-hot start strobe for a collection transfer |
| coll_done | input | NODES | Per-node done strobe for a collection transfer |
| sink_blk_valid | output | 1 | One-cycle pulse: a result block has been delivered |
| coll_node | output | PTR_W | Current collection source |

## Verification
The bench first holds node 0 busy while every other node is ready. A design that skips ahead would fire a start at node 1, and the per-cycle pointer checks would catch the skip. During random traffic, the bench also pulses done on nodes that are not in flight. A design that accepts any done bit would then release early, advance its pointer and break the one-cycle release timing. Random processing latencies and random sink stalls let results become ready out of rotation order. A collector that chased whichever node was ready would then deliver block ids out of sequence, and the scoreboard would flag it. The run covers many wraps of both pointers, so an off-by-one in the wrap shows up as a wrong target node.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    // Next position in the rotation over lim nodes.
    function automatic int wrap_inc(input int cur, input int lim);
        return (cur + 1 >= lim) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/rr_idx_decode.sv
module rr_idx_decode #(
    parameter int NODES = 4,
    parameter int PTR_W = 2
) (
    input  logic [PTR_W-1:0] idx,
    output logic [NODES-1:0] onehot
);
    for (genvar g = 0; g < NODES; g++) begin : g_bit
        assign onehot[g] = (idx == PTR_W'(g));
    end
endmodule

// File: rtl/rr_seq_chan.sv
module rr_seq_chan
    import rr_pkg::*;
#(
    parameter int NODES = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             side_ok,
    input  logic [NODES-1:0] node_ok,
    input  logic [NODES-1:0] node_done,
    output logic [NODES-1:0] start_o,
    output logic             release_o,
    output logic [PTR_W-1:0] ptr_o
);
    ch_state_e        state_q;
    logic [PTR_W-1:0] ptr_q;
    logic             rel_q;
    logic [NODES-1:0] start_q;
    logic [NODES-1:0] sel_vec;
    logic             go;
    logic             fin;

    rr_idx_decode #(.NODES(NODES), .PTR_W(PTR_W)) u_dec (
        .idx    (ptr_q),
        .onehot (sel_vec)
    );

    // Begin only when idle, past the release cycle, and both ends are ready.
    assign go  = (state_q == CH_IDLE) && !rel_q && side_ok && node_ok[ptr_q];
    assign fin = (state_q == CH_BUSY) && node_done[ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            ptr_q   <= '0;
            rel_q   <= 1'b0;
            start_q <= '0;
        end else begin
            rel_q   <= fin;
            start_q <= go ? sel_vec : '0;
            if (go) begin
                state_q <= CH_BUSY;
            end else if (fin) begin
                state_q <= CH_IDLE;
                ptr_q   <= PTR_W'(wrap_inc(int'(ptr_q), NODES));
            end
        end
    end

    assign start_o   = start_q;
    assign release_o = rel_q;
    assign ptr_o     = ptr_q;

    a_r2_onehot_start: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_q));

    a_r2_start_needs_ready: assert property (@(posedge clk) disable iff (rst)
        (|start_q) |-> ($past(side_ok) && $past(node_ok[ptr_q])));

    a_r3_ptr_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < NODES);

    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !((state_q == CH_BUSY) && node_done[ptr_q]) |=> $stable(ptr_q));

    a_r6_single_flight: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CH_BUSY) && !node_done[ptr_q]) |=> ((state_q == CH_BUSY) && (start_q == '0)));

    a_r7_no_start_on_release: assert property (@(posedge clk) disable iff (rst)
        rel_q |-> (start_q == '0));

endmodule

// File: rtl/rr_block_mover.sv
module rr_block_mover #(
    parameter int NODES = 4,
    parameter int PTR_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_blk_ready,
    output logic             src_blk_release,
    input  logic [NODES-1:0] node_in_free,
    output logic [NODES-1:0] dist_start,
    input  logic [NODES-1:0] dist_done,
    output logic [PTR_W-1:0] dist_node,
    input  logic [NODES-1:0] node_res_ready,
    input  logic             sink_free,
    output logic [NODES-1:0] coll_start,
    input  logic [NODES-1:0] coll_done,
    output logic             sink_blk_valid,
    output logic [PTR_W-1:0] coll_node
);
    // Distribution: upstream block is the common side, node input buffers vary.
    rr_seq_chan #(.NODES(NODES), .PTR_W(PTR_W)) u_dist (
        .clk       (clk),
        .rst       (rst),
        .side_ok   (src_blk_ready),
        .node_ok   (node_in_free),
        .node_done (dist_done),
        .start_o   (dist_start),
        .release_o (src_blk_release),
        .ptr_o     (dist_node)
    );

    // Collection: the output node is the common side, node results vary.
    rr_seq_chan #(.NODES(NODES), .PTR_W(PTR_W)) u_coll (
        .clk       (clk),
        .rst       (rst),
        .side_ok   (sink_free),
        .node_ok   (node_res_ready),
        .node_done (coll_done),
        .start_o   (coll_start),
        .release_o (sink_blk_valid),
        .ptr_o     (coll_node)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (dist_start == '0 && coll_start == '0 && !src_blk_release && !sink_blk_valid));

    a_r7_release_alone: assert property (@(posedge clk) disable iff (rst)
        src_blk_release |-> (dist_start == '0));

endmodule

// File: tb/sim_rr_block_mover.sv
`timescale 1ns/1ps
module sim_rr_block_mover;
    localparam int N     = 4;
    localparam int PW    = 2;
    localparam int TOTAL = 120;

    logic          clk = 1'b0;
    logic          rst;
    logic          src_blk_ready;
    logic          src_blk_release;
    logic [N-1:0]  node_in_free;
    logic [N-1:0]  dist_start;
    logic [N-1:0]  dist_done;
    logic [PW-1:0] dist_node;
    logic [N-1:0]  node_res_ready;
    logic          sink_free;
    logic [N-1:0]  coll_start;
    logic [N-1:0]  coll_done;
    logic          sink_blk_valid;
    logic [PW-1:0] coll_node;

    always #10 clk = ~clk;

    rr_block_mover #(.NODES(N)) u0 (
        .clk(clk), .rst(rst),
        .src_blk_ready(src_blk_ready), .src_blk_release(src_blk_release),
        .node_in_free(node_in_free), .dist_start(dist_start),
        .dist_done(dist_done), .dist_node(dist_node),
        .node_res_ready(node_res_ready), .sink_free(sink_free),
        .coll_start(coll_start), .coll_done(coll_done),
        .sink_blk_valid(sink_blk_valid), .coll_node(coll_node)
    );

    int n_chk = 0;
    int n_fail = 0;

    bit has_in [N];
    bit has_out[N];
    int in_id  [N];
    int out_id [N];
    int ptimer [N];
    int next_in, exp_dist, exp_coll, exp_out;
    bit dpend, cpend, d_rel_exp, c_rel_exp;
    int dnode, ddly, cnode, cdly, cid;
    int seed_sink;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int idx_of(input logic [N-1:0] v);
        for (int k = 0; k < N; k++) if (v[k]) return k;
        return -1;
    endfunction

    function automatic int rot(input int p);
        return (p + 1) % N;
    endfunction

    task automatic env_step();
        int k;
        // ---- observe distribution ----
        chk(src_blk_release == d_rel_exp, "R7 release timing", int'(src_blk_release), int'(d_rel_exp));
        if (src_blk_release) begin
            chk(dist_start == '0, "R7 no start with release", int'(dist_start), 0);
            exp_dist = rot(exp_dist);
            next_in++;
        end
        d_rel_exp = 1'b0;
        if (|dist_start) begin
            k = idx_of(dist_start);
            chk($onehot(dist_start), "R2 dist one-hot", int'(dist_start), 1 << k);
            chk(k == exp_dist, "R3 dist order", k, exp_dist);
            chk(src_blk_ready && node_in_free[k], "R2 dist both ready", int'(node_in_free[k]), 1);
            chk(!dpend, "R6 dist single flight", int'(dpend), 0);
            dpend = 1'b1; dnode = k; ddly = int'($urandom % 4);
        end
        chk(int'(dist_node) == exp_dist, "R5 dist pointer", int'(dist_node), exp_dist);
        // ---- observe collection ----
        chk(sink_blk_valid == c_rel_exp, "R7 deliver timing", int'(sink_blk_valid), int'(c_rel_exp));
        if (sink_blk_valid) begin
            chk(cid == exp_out, "R8 output order", cid, exp_out);
            exp_out++;
            exp_coll = rot(exp_coll);
        end
        c_rel_exp = 1'b0;
        if (|coll_start) begin
            k = idx_of(coll_start);
            chk($onehot(coll_start), "R2 coll one-hot", int'(coll_start), 1 << k);
            chk(k == exp_coll, "R4 coll order", k, exp_coll);
            chk(node_res_ready[k] && sink_free, "R2 coll both ready", int'(node_res_ready[k]), 1);
            chk(!cpend, "R6 coll single flight", int'(cpend), 0);
            cpend = 1'b1; cnode = k; cid = out_id[k]; cdly = int'($urandom % 4);
        end
        chk(int'(coll_node) == exp_coll, "R5 coll pointer", int'(coll_node), exp_coll);
        // ---- drive next inputs ----
        dist_done = '0;
        coll_done = '0;
        if (dpend) begin
            if (ddly == 0) begin
                dist_done[dnode] = 1'b1;
                has_in[dnode] = 1'b1;
                in_id[dnode] = next_in;
                ptimer[dnode] = 1 + int'($urandom % 12);
                dpend = 1'b0;
                d_rel_exp = 1'b1;
            end else begin
                ddly--;
                if ($urandom % 4 == 0) dist_done[rot(dnode)] = 1'b1; // R6 stray done
            end
        end
        if (cpend) begin
            if (cdly == 0) begin
                coll_done[cnode] = 1'b1;
                has_out[cnode] = 1'b0;
                cpend = 1'b0;
                c_rel_exp = 1'b1;
            end else begin
                cdly--;
                if ($urandom % 4 == 0) coll_done[rot(cnode)] = 1'b1; // R6 stray done
            end
        end
        for (int j = 0; j < N; j++) begin
            if (has_in[j] && !has_out[j]) begin
                if (ptimer[j] == 0) begin
                    has_out[j] = 1'b1; out_id[j] = in_id[j]; has_in[j] = 1'b0;
                end else ptimer[j]--;
            end
        end
        src_blk_ready = (next_in < TOTAL) && ($urandom % 4 != 0);
        sink_free     = ($urandom % 4 != 0);
        for (int j = 0; j < N; j++) begin
            node_in_free[j]   = !has_in[j];
            node_res_ready[j] = has_out[j];
        end
    endtask

    initial begin
        int cyc;
        seed_sink = int'($urandom(32'd1234));
        rst = 1'b1;
        src_blk_ready = 1'b0; sink_free = 1'b0;
        node_in_free = '0; node_res_ready = '0;
        dist_done = '0; coll_done = '0;
        for (int j = 0; j < N; j++) begin
            has_in[j] = 0; has_out[j] = 0; in_id[j] = 0; out_id[j] = 0; ptimer[j] = 0;
        end
        next_in = 0; exp_dist = 0; exp_coll = 0; exp_out = 0;
        dpend = 0; cpend = 0; d_rel_exp = 0; c_rel_exp = 0;
        dnode = 0; ddly = 0; cnode = 0; cdly = 0; cid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(dist_node == '0 && coll_node == '0, "R1 pointers", int'(dist_node), 0);
        chk(dist_start == '0 && coll_start == '0, "R1 starts", int'(dist_start), 0);
        chk(!src_blk_release && !sink_blk_valid, "R1 pulses", int'(src_blk_release), 0);
        rst = 1'b0;
        // R5 directed: node 0 not ready, all other nodes ready
        src_blk_ready = 1'b1; node_in_free = 4'b1110;
        sink_free = 1'b1; node_res_ready = 4'b1110;
        repeat (20) begin
            @(negedge clk);
            chk(dist_start == '0, "R5 dist no skip", int'(dist_start), 0);
            chk(coll_start == '0, "R5 coll no skip", int'(coll_start), 0);
            chk(dist_node == '0 && coll_node == '0, "R5 pointers held", int'(dist_node), 0);
        end
        for (int j = 0; j < N; j++) begin
            node_in_free[j] = 1'b1; node_res_ready[j] = 1'b0;
        end
        // Random traffic
        cyc = 0;
        while (exp_out < TOTAL && cyc < 100000) begin
            @(negedge clk);
            env_step();
            cyc++;
        end
        chk(cyc < 100000, "WATCHDOG", cyc, 100000);
        chk(exp_out == TOTAL, "R8 all delivered", exp_out, TOTAL);
        chk(next_in == TOTAL, "R8 all released", next_in, TOTAL);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule